// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the outcomes of the most recently resolved branches, one bit per branch. It also keeps a table of 2-bit saturating counters. The counter for a branch is selected by XORing the word-address bits of its PC with that history. Because the same branch gets different counters under different histories, the block can learn correlated and periodic behaviour, not only a fixed bias per address.

Fetch presents a PC on the lookup port and gets a combinational taken/not-taken answer in the same cycle. When a branch resolves, the back end presents its PC and actual outcome on the update port. One clock later the selected counter has moved one step toward that outcome and the outcome has entered the history. Index width and history depth are parameters. A deeper history separates more patterns but takes longer to train.

Top module: `gxp_predictor`

## Requirements
- R1: A cycle with `rst` high sets every counter to weakly not-taken (2'b01) and clears the history, so after reset every lookup predicts not-taken.
- R2: `lkp_taken` equals bit 1 of the counter at index `lkp_pc[IDX_W+1:2] XOR history`, where the history is zero-extended to IDX_W bits. The result is valid in the same cycle as `lkp_pc`.
- R3: An update with `upd_taken`=1 increments the selected counter by one, and a counter at 2'b11 stays at 2'b11.
- R4: An update with `upd_taken`=0 decrements the selected counter by one, and a counter at 2'b00 stays at 2'b00.
- R5: The update index is formed from `upd_pc` and the history as it was before that update.
- R6: On each update, the history shifts left by one, `upd_taken` enters bit 0, and the oldest bit is dropped.
- R7: When a lookup and an update happen in the same cycle, the lookup sees the counters and history as they were before the update.
- R8: While `upd_valid` is low, `upd_pc` and `upd_taken` change neither the counters nor the history.
- R9: With HIST_W=3, a single branch whose outcomes repeat 1,1,1,0 is predicted correctly every time once its four history patterns have been trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lkp_pc | input | PC_W | PC of the branch being fetched |
| lkp_taken | output | 1 | Predicted direction for `lkp_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
On every cycle, the assertions check the following:
- the history enters each outcome at bit 0 and holds while no update arrives;
- an updated counter never moves against the outcome;
- counters never wrap past 2'b11 or below 2'b00.

Only the bench's scenarios can show the rest. Its reference model checks that the XOR index picks the right counter for lookup and update, that the update uses the history from before the update, and that a same-cycle lookup sees old state. The 1,1,1,0 loop shows that the block learns a periodic pattern and reaches full accuracy.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_INIT = CTR_WNT;

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t n;
        n = c;
        if (taken) begin
            if (c != CTR_ST) n = ctr_t'(c + 2'd1);
        end else begin
            if (c != CTR_SNT) n = ctr_t'(c - 2'd1);
        end
        return n;
    endfunction

    function automatic logic ctr_dir(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/gxp_hist.sv
module gxp_hist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], din};
    end

    // R6: the newest outcome lands in bit 0
    p_newest_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist[0] == $past(din));

    // R6: older bits move up by one position
    p_age_shift_r6: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));

    // R8: without an update the history is frozen
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/gxp_hash.sv
module gxp_hash #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    logic [IDX_W-1:0] hist_ext;
    logic             unused_pc_bits;

    always_comb begin
        hist_ext               = '0;
        hist_ext[HIST_W-1:0]   = hist;
        idx                    = pc[IDX_W+1:2] ^ hist_ext;
    end

    assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
endmodule

// File: rtl/gxp_pht.sv
module gxp_pht
    import gxp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t ctr [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
        end
    end

    assign rd_taken = ctr_dir(ctr[rd_idx]);

    // R3: a taken update never lowers the counter, and a saturated one stays saturated
    p_taken_mono_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken |=> ctr[$past(wr_idx)] >= $past(ctr[wr_idx]));
    p_no_wrap_hi_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && ctr[wr_idx] == CTR_ST |=> ctr[$past(wr_idx)] == CTR_ST);

    // R4: a not-taken update never raises the counter, and a counter at zero stays there
    p_nt_mono_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken |=> ctr[$past(wr_idx)] <= $past(ctr[wr_idx]));
    p_no_wrap_lo_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && ctr[wr_idx] == CTR_SNT |=> ctr[$past(wr_idx)] == CTR_SNT);
endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            lkp_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  lkp_idx;
    logic [IDX_W-1:0]  upd_idx;

    gxp_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .din      (upd_taken),
        .hist     (ghist)
    );

    gxp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_lkp (
        .pc   (lkp_pc),
        .hist (ghist),
        .idx  (lkp_idx)
    );

    gxp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_upd (
        .pc   (upd_pc),
        .hist (ghist),
        .idx  (upd_idx)
    );

    gxp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lkp_idx),
        .rd_taken (lkp_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    // R7: a lookup aimed at the entry being updated sees the old value; the
    // prediction for that PC cannot move until the next edge
    p_old_view_r7: assert property (@(posedge clk) disable iff (rst)
        upd_valid && lkp_idx == upd_idx |-> lkp_taken == u_pht.ctr[upd_idx][1]);
endmodule

// File: tb/gxp_predictor_tb.sv
module gxp_predictor_tb;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 6;
    localparam int HIST_W = 3;
    localparam int ENT    = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] lkp_pc;
    logic            lkp_taken;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc;
    logic            upd_taken;

    int n_vec  = 0;
    int n_fail = 0;
    int m_ctr [ENT];
    int m_hist;

    always #5 clk = ~clk;

    gxp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .lkp_pc    (lkp_pc),
        .lkp_taken (lkp_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    function automatic int midx(input logic [PC_W-1:0] pc);
        return ((int'(pc) >>> 2) ^ m_hist) & (ENT - 1);
    endfunction

    function automatic int mpred(input logic [PC_W-1:0] pc);
        return (m_ctr[midx(pc)] >= 2) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ENT; i++) m_ctr[i] = 1;
        m_hist = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 1'b0; lkp_pc = '0; upd_pc = '0; upd_taken = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one cycle: drive, compare the combinational prediction, clock, update model
    task automatic step(input string req, input logic [PC_W-1:0] lpc,
                        input logic uv, input logic [PC_W-1:0] upc, input logic ut);
        int i;
        @(negedge clk);
        lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        check(req, int'(lkp_taken), mpred(lpc));
        @(posedge clk);
        if (uv) begin
            i = midx(upc);
            if (ut && m_ctr[i] < 3) m_ctr[i]++;
            if (!ut && m_ctr[i] > 0) m_ctr[i]--;
            m_hist = ((m_hist << 1) | int'(ut)) & ((1 << HIST_W) - 1);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; upd_valid = 1'b0; lkp_pc = '0; upd_pc = '0; upd_taken = 1'b0;
        model_reset();
        do_reset();

        // R1: every lookup after reset is not-taken
        for (int k = 0; k < ENT; k++) begin
            step("R1", PC_W'(k * 4), 1'b0, '0, 1'b0);
            check("R1", int'(lkp_taken), 0);
        end

        // R3: repeated taken at one PC saturates; history settles at 111
        for (int k = 0; k < 8; k++) step("R3", 32'h100, 1'b1, 32'h100, 1'b1);
        step("R3", 32'h100, 1'b0, '0, 1'b0);
        check("R3", int'(lkp_taken), 1);

        // R4: repeated not-taken drives counters down to zero without wrapping
        for (int k = 0; k < 8; k++) step("R4", 32'h100, 1'b1, 32'h100, 1'b0);
        step("R4", 32'h100, 1'b0, '0, 1'b0);
        check("R4", int'(lkp_taken), 0);

        // R8: toggling update data with valid low changes nothing
        for (int k = 0; k < 16; k++)
            step("R8", PC_W'(k * 4), 1'b0, PC_W'(k * 4), k[0]);

        // R7: lookup and update of the same entry in one cycle
        do_reset();
        step("R7", 32'h20, 1'b1, 32'h20, 1'b1);   // ctr[8] 1->2, hist 001
        step("R7", 32'h24, 1'b1, 32'h24, 1'b0);   // idx 9^1=8: old value 2, predicts taken
        step("R7", 32'h20, 1'b0, '0, 1'b0);

        // R2, R5, R6: mixed random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0] a, b;
            a = PC_W'($urandom_range(0, 255));
            b = PC_W'($urandom_range(0, 255));
            step("R2_R5_R6", a, 1'($urandom_range(0, 3) != 0), b, 1'($urandom_range(0, 1)));
        end

        // R9: loop pattern 1,1,1,0 at one PC; full accuracy after training
        do_reset();
        for (int k = 0; k < 200; k++) begin
            logic o;
            o = (k % 4) != 3;
            step("R9", 32'h40, 1'b1, 32'h40, o);
            if (k >= 40) check("R9", int'(lkp_taken), int'(o));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule